// File: doc/BRIEF.md
# Ethernet PAUSE Frame Generator

This block builds a complete MAC control PAUSE frame, byte by byte, on a valid/ready output stream. A request for a frame comes from one of two sources. Software can raise a manual request. An automatic trigger watches the free space left in the receive buffer and compares it with a watermark. On its own, the block handles only the frame body: destination, source, type, opcode, pause time and zero padding up to the 60-byte minimum. Preamble, start delimiter and frame check sequence are added later by the MAC.

The automatic trigger reacts to crossings of the watermark, not to levels. When free space drops below the watermark, the block sends one frame that carries the programmed pause time. When free space climbs back to the watermark or above it, the block sends one frame with a pause time of zero, so the link partner starts sending again at once. The pause time is counted in quanta of 512 bit times. The block captures the pause time and the source address at the moment a frame starts. Requests that arrive while a frame is on the stream are held and served once that frame ends. The block generates frames only on a full-duplex link.

Output back-pressure follows the usual valid/ready rules. A byte moves on every clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the data byte and both frame markers stay unchanged. `out_valid` never drops in the middle of a frame.

Top module: `pause_gen`

## Requirements
- R1: After reset `out_valid` is low. Each frame is exactly 60 transferred bytes. `out_sof` is high only with byte 0 and `out_eof` only with byte 59, where bytes are numbered from 0 in transfer order.
- R2: Bytes 0 to 5 carry the reserved multicast destination: 0x01, 0x80, 0xC2, 0x00, 0x00, 0x01.
- R3: Bytes 6 to 11 carry `src_mac`, most significant byte first (bits 47:40 in byte 6). The value is captured on the edge where the frame starts.
- R4: Bytes 12 and 13 are 0x88 and 0x08 (the type). Bytes 14 and 15 are 0x00 and 0x01 (the opcode).
- R5: Bytes 16 and 17 carry the pause time, high byte first. For a pause frame this is `pause_quanta`, captured when the frame starts. For a resume frame it is zero. Bytes 18 to 59 are zero.
- R6: `manual_req` sampled high on a rising edge while `full_duplex` is high queues one pause frame. If the block is idle, `out_valid` is still low after that edge and rises on the following edge, carrying byte 0.
- R7: With `auto_en` high, free space changing from not below the watermark to strictly below it (`free_space < watermark`) between two sampling edges queues exactly one pause frame. Free space equal to the watermark does not count as below. Further changes that stay below queue nothing. The latency is the same as in R6.
- R8: With `auto_en` high, free space changing from below the watermark back to at or above it queues exactly one frame with a pause time of zero.
- R9: With `auto_en` low, watermark crossings queue nothing, and setting `auto_en` later does not replay them.
- R10: While `full_duplex` is low, manual requests and crossings are discarded. They send no frame, either then or after `full_duplex` returns high.
- R11: A request that arrives during a frame is held and served after it. `out_valid` is low for exactly one cycle after the end-of-frame transfer, then the next frame starts. Repeated requests of one kind collapse into one frame. When a pause and a resume are both pending, the pause frame goes first.
- R12: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_sof` and `out_eof` hold their values on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| full_duplex | input | 1 | High when the link is full duplex; frames are generated only then |
| auto_en | input | 1 | Enables the watermark-driven trigger |
| manual_req | input | 1 | Software request for a pause frame, sampled each edge |
| pause_quanta | input | 16 | Pause time to advertise, in units of 512 bit times |
| src_mac | input | 48 | Station source address |
| free_space | input | FREE_W | Free space left in the receive buffer |
| watermark | input | FREE_W | Threshold for the automatic trigger |
| out_ready | input | 1 | Downstream is ready to accept a byte |
| out_valid | output | 1 | A frame byte is present on `out_data` |
| out_data | output | 8 | Frame byte |
| out_sof | output | 1 | Marks the first byte of a frame |
| out_eof | output | 1 | Marks the last byte of a frame |

## Verification
A request sampled on edge k is latched on that edge. The frame starts on edge k+1, so byte 0 shows up in the cycle after k+1. The bench drives inputs and samples outputs on the falling edge, so it reads `out_valid` low one half-cycle after the request edge and high one cycle later. Each byte is counted as transferred only in the sample where `out_ready` was already high, so that edge accepts it. After the end-of-frame transfer, the bench expects exactly one idle sample before the next byte 0. Checks for an ignored request watch the output for several cycles after the stimulus and again after the enabling input comes back.

// File: rtl/pause_pkg.sv
package pause_pkg;

  // Frame constants
  localparam logic [47:0] PAUSE_DST_ADDR = 48'h0180_C200_0001;
  localparam logic [15:0] MAC_CTRL_TYPE  = 16'h8808;
  localparam logic [15:0] PAUSE_OPCODE   = 16'h0001;

  // Field start positions (byte index in the frame)
  localparam int unsigned DST_AT      = 0;
  localparam int unsigned SRC_AT      = 6;
  localparam int unsigned HDR_AT      = 12;
  localparam int unsigned PAD_AT      = 18;
  localparam int unsigned MIN_FRAME   = 60;

  typedef enum logic {
    KIND_PAUSE  = 1'b0,
    KIND_RESUME = 1'b1
  } frame_kind_e;

endpackage

// File: rtl/pause_trigger.sv
module pause_trigger #(
  parameter int unsigned FREE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full_duplex,
  input  logic              auto_en,
  input  logic              manual_req,
  input  logic [FREE_W-1:0] free_space,
  input  logic [FREE_W-1:0] watermark,
  input  logic              take_pause,
  input  logic              take_resume,
  output logic              pend_pause,
  output logic              pend_resume
);

  logic below;
  logic below_q;
  logic fire_pause;
  logic fire_resume;

  // Level compare; crossings are found against the previous edge
  assign below = (free_space < watermark);

  assign fire_pause  = full_duplex &
                       (manual_req | (auto_en & below & ~below_q));
  assign fire_resume = full_duplex & auto_en & ~below & below_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      below_q     <= 1'b0;
      pend_pause  <= 1'b0;
      pend_resume <= 1'b0;
    end else begin
      // Tracked in every mode so that enabling never replays a stale edge
      below_q     <= below;
      pend_pause  <= (pend_pause  & ~take_pause)  | fire_pause;
      pend_resume <= (pend_resume & ~take_resume) | fire_resume;
    end
  end

endmodule

// File: rtl/pause_sequencer.sv
module pause_sequencer #(
  parameter int unsigned FRAME_LEN = 60,
  localparam int unsigned IDX_W    = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend_pause,
  input  logic             pend_resume,
  input  logic [15:0]      pause_quanta,
  input  logic [47:0]      src_mac,
  input  logic             out_ready,
  output logic             take_pause,
  output logic             take_resume,
  output logic             active,
  output logic [IDX_W-1:0] idx,
  output logic [15:0]      frame_time,
  output logic [47:0]      frame_src,
  output logic             sof,
  output logic             eof
);

  import pause_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic        start;
  logic        last;
  frame_kind_e kind;

  assign start       = ~active & (pend_pause | pend_resume);
  // Pause outranks resume when both wait
  assign kind        = pend_pause ? KIND_PAUSE : KIND_RESUME;
  assign take_pause  = start & (kind == KIND_PAUSE);
  assign take_resume = start & (kind == KIND_RESUME);
  assign last        = (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      idx        <= '0;
      frame_time <= '0;
      frame_src  <= '0;
    end else if (start) begin
      active     <= 1'b1;
      idx        <= '0;
      frame_time <= (kind == KIND_PAUSE) ? pause_quanta : 16'h0000;
      frame_src  <= src_mac;
    end else if (active && out_ready) begin
      if (last) begin
        active <= 1'b0;
        idx    <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  assign sof = active & (idx == '0);
  assign eof = active & last;

endmodule

// File: rtl/pause_byte_sel.sv
module pause_byte_sel #(
  parameter int unsigned IDX_W = 6
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [15:0]      frame_time,
  input  logic [47:0]      frame_src,
  output logic [7:0]       byte_o
);

  import pause_pkg::*;

  logic [31:0] pos;
  logic [47:0] hdr;

  always_comb begin
    pos    = 32'(idx);
    hdr    = {MAC_CTRL_TYPE, PAUSE_OPCODE, frame_time};
    byte_o = 8'h00;
    if (pos < SRC_AT) begin
      byte_o = 8'(PAUSE_DST_ADDR >> (8 * (SRC_AT - 1 - pos)));
    end else if (pos < HDR_AT) begin
      byte_o = 8'(frame_src >> (8 * (HDR_AT - 1 - pos)));
    end else if (pos < PAD_AT) begin
      byte_o = 8'(hdr >> (8 * (PAD_AT - 1 - pos)));
    end
  end

endmodule

// File: rtl/pause_gen.sv
module pause_gen #(
  parameter int unsigned FREE_W    = 12,
  parameter int unsigned FRAME_LEN = 60,
  localparam int unsigned IDX_W    = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full_duplex,
  input  logic              auto_en,
  input  logic              manual_req,
  input  logic [15:0]       pause_quanta,
  input  logic [47:0]       src_mac,
  input  logic [FREE_W-1:0] free_space,
  input  logic [FREE_W-1:0] watermark,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_sof,
  output logic              out_eof
);

  logic             pend_pause;
  logic             pend_resume;
  logic             take_pause;
  logic             take_resume;
  logic             active;
  logic [IDX_W-1:0] idx;
  logic [15:0]      frame_time;
  logic [47:0]      frame_src;

  pause_trigger #(.FREE_W(FREE_W)) u_trig (
    .clk         (clk),
    .rst_n       (rst_n),
    .full_duplex (full_duplex),
    .auto_en     (auto_en),
    .manual_req  (manual_req),
    .free_space  (free_space),
    .watermark   (watermark),
    .take_pause  (take_pause),
    .take_resume (take_resume),
    .pend_pause  (pend_pause),
    .pend_resume (pend_resume)
  );

  pause_sequencer #(.FRAME_LEN(FRAME_LEN)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .pend_pause   (pend_pause),
    .pend_resume  (pend_resume),
    .pause_quanta (pause_quanta),
    .src_mac      (src_mac),
    .out_ready    (out_ready),
    .take_pause   (take_pause),
    .take_resume  (take_resume),
    .active       (active),
    .idx          (idx),
    .frame_time   (frame_time),
    .frame_src    (frame_src),
    .sof          (out_sof),
    .eof          (out_eof)
  );

  pause_byte_sel #(.IDX_W(IDX_W)) u_sel (
    .idx        (idx),
    .frame_time (frame_time),
    .frame_src  (frame_src),
    .byte_o     (out_data)
  );

  assign out_valid = active;

endmodule

// File: rtl/pause_gen_chk.sv
module pause_gen_chk #(
  parameter int unsigned FRAME_LEN = 60,
  localparam int unsigned CNT_W    = $clog2(FRAME_LEN + 1)
) (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sof,
  input logic       out_eof
);

  logic [CNT_W-1:0] beats;

  // Independent count of accepted bytes within the current frame
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beats <= '0;
    end else if (out_valid && out_ready) begin
      beats <= out_eof ? '0 : beats + 1'b1;
    end
  end

  // R12
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)));

  // R1
  sof_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof) |-> (beats == '0));

  // R1
  eof_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eof) |-> (beats == CNT_W'(FRAME_LEN - 1)));

  // R1
  idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (beats == '0));

  // R2
  sof_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> (out_valid && out_data == 8'h01));

  // R11
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eof) |=> !out_valid);

endmodule

bind pause_gen pause_gen_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_sof   (out_sof),
  .out_eof   (out_eof)
);

// File: tb/sim_pause_gen.sv
module sim_pause_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        full_duplex;
  logic        auto_en;
  logic        manual_req;
  logic [15:0] pause_quanta;
  logic [47:0] src_mac;
  logic [11:0] free_space;
  logic [11:0] watermark;
  logic        out_ready;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_sof;
  logic        out_eof;

  int checks = 0;
  int errors = 0;

  logic [7:0] fb [64];
  logic       fs [64];
  logic       fe [64];
  int         nbytes;
  int         stall_bad;

  always #10 clk = ~clk;

  pause_gen u0 (
    .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .auto_en(auto_en),
    .manual_req(manual_req), .pause_quanta(pause_quanta), .src_mac(src_mac),
    .free_space(free_space), .watermark(watermark), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int i, logic [15:0] t, logic [47:0] s);
    if (i < 6) begin
      case (i)
        1: return 8'h80;
        2: return 8'hC2;
        3, 4: return 8'h00;
        default: return 8'h01;
      endcase
    end
    if (i < 12) return 8'(s >> (8 * (11 - i)));
    case (i)
      12: return 8'h88;
      13: return 8'h08;
      14: return 8'h00;
      15: return 8'h01;
      16: return t[15:8];
      17: return t[7:0];
      default: return 8'h00;
    endcase
  endfunction

  // Ends at the falling edge after the request edge
  task automatic pulse_manual();
    manual_req = 1'b1;
    @(negedge clk);
    manual_req = 1'b0;
  endtask

  // Valid still low now, byte 0 one cycle later
  task automatic expect_start(input string req);
    #1;
    chk(!out_valid, req, 64'(out_valid), 64'd0);
    @(negedge clk);
    #1;
    chk(out_valid && out_sof && out_data == 8'h01, req,
        64'({out_valid, out_sof, out_data}), 64'h301);
  endtask

  task automatic watch_idle(input int n, input string req);
    bit ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      if (out_valid) ok = 1'b0;
    end
    chk(ok, req, 64'(!ok), 64'd0);
  endtask

  // Entered at a falling edge with byte 0 presented
  task automatic collect(input int mode);
    bit         held = 1'b0;
    bit         done = 1'b0;
    logic [7:0] hd = 8'h00;
    logic       hs = 1'b0;
    logic       he = 1'b0;
    int         g = 0;
    nbytes    = 0;
    stall_bad = 0;
    while (!done && g < 500) begin
      case (mode)
        1:       out_ready = (g % 2) == 1;
        2:       out_ready = (g % 3) != 0;
        default: out_ready = 1'b1;
      endcase
      #1;
      if (held && !(out_valid && out_data == hd && out_sof == hs && out_eof == he))
        stall_bad++;
      held = 1'b0;
      if (out_valid) begin
        if (out_ready) begin
          if (nbytes < 64) begin
            fb[nbytes] = out_data;
            fs[nbytes] = out_sof;
            fe[nbytes] = out_eof;
          end
          nbytes++;
          if (out_eof) done = 1'b1;
        end else begin
          held = 1'b1;
          hd = out_data;
          hs = out_sof;
          he = out_eof;
        end
      end else if (nbytes > 0) begin
        stall_bad++;
      end
      @(negedge clk);
      g++;
    end
    out_ready = 1'b1;
  endtask

  task automatic verify(input logic [15:0] t, input logic [47:0] s, input string tag);
    int nsof = 0;
    int neof = 0;
    bit ok2 = 1'b1, ok3 = 1'b1, ok4 = 1'b1, ok5 = 1'b1;
    logic [7:0] a = 8'h00, e = 8'h00;
    for (int i = 0; i < 60 && i < nbytes; i++) begin
      if (fs[i]) nsof++;
      if (fe[i]) neof++;
      if (fb[i] !== exp_byte(i, t, s)) begin
        a = fb[i];
        e = exp_byte(i, t, s);
        if (i < 6) ok2 = 1'b0;
        else if (i < 12) ok3 = 1'b0;
        else if (i < 16) ok4 = 1'b0;
        else ok5 = 1'b0;
      end
    end
    chk(nbytes == 60 && nsof == 1 && neof == 1 && fs[0] && fe[59],
        {"R1 length/markers ", tag}, 64'(nbytes), 64'd60);
    chk(ok2, {"R2 destination ", tag}, 64'(a), 64'(e));
    chk(ok3, {"R3 source ", tag}, 64'(a), 64'(e));
    chk(ok4, {"R4 type/opcode ", tag}, 64'(a), 64'(e));
    chk(ok5, {"R5 time/pad ", tag}, 64'(a), 64'(e));
    chk(stall_bad == 0, {"R12 hold under stall ", tag}, 64'(stall_bad), 64'd0);
  endtask

  task automatic gap_then_start(input string req);
    #1;
    chk(!out_valid, req, 64'(out_valid), 64'd0);
    @(negedge clk);
    #1;
    chk(out_valid && out_sof, req, 64'({out_valid, out_sof}), 64'h3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] q;
    logic [47:0] s;
    rst_n = 1'b0; full_duplex = 1'b1; auto_en = 1'b0; manual_req = 1'b0;
    pause_quanta = 16'h0000; src_mac = '0; free_space = 12'hFFF;
    watermark = 12'd100; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid, "R1 reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    watch_idle(3, "R1 idle after reset");

    // Manual sweep over pause times and stall patterns (R6)
    for (int k = 0; k < 4; k++) begin
      case (k)
        0: q = 16'h0000;
        1: q = 16'hFFFF;
        2: q = 16'h1234;
        default: q = 16'h8001;
      endcase
      s = {8'h02, 8'(k * 17), 32'hA5C3_0F00 ^ 32'(k)};
      pause_quanta = q; src_mac = s;
      @(negedge clk);
      pulse_manual();
      expect_start("R6 manual latency");
      collect(k % 3);
      verify(q, s, "R6 manual");
      watch_idle(3, "R6 single frame");
    end

    // Capture at start and queued request (R3, R5, R11)
    pause_quanta = 16'h0A0B; src_mac = 48'h1122_3344_5566;
    pulse_manual();
    expect_start("R6 manual latency");
    pause_quanta = 16'h7777; src_mac = 48'hCAFE_0000_BEEF;
    out_ready = 1'b0; manual_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    manual_req = 1'b0;
    collect(0);
    verify(16'h0A0B, 48'h1122_3344_5566, "R3 R5 capture");
    gap_then_start("R11 queued start after gap");
    collect(2);
    verify(16'h7777, 48'hCAFE_0000_BEEF, "R11 queued");
    watch_idle(6, "R11 repeats collapse");

    // Automatic trigger (R7, R8)
    auto_en = 1'b1; pause_quanta = 16'h0100; src_mac = 48'h0A0B_0C0D_0E0F;
    free_space = 12'd100;
    watch_idle(5, "R7 equal is not below");
    free_space = 12'd99;
    @(negedge clk);
    expect_start("R7 auto latency");
    collect(1);
    verify(16'h0100, 48'h0A0B_0C0D_0E0F, "R7 auto pause");
    free_space = 12'd40;
    watch_idle(5, "R7 one frame per crossing");
    free_space = 12'd100;
    @(negedge clk);
    expect_start("R8 auto resume latency");
    collect(0);
    verify(16'h0000, 48'h0A0B_0C0D_0E0F, "R8 auto resume");

    // Auto disabled (R9)
    auto_en = 1'b0;
    free_space = 12'd10;
    watch_idle(6, "R9 no frame on drop");
    free_space = 12'd500;
    watch_idle(6, "R9 no frame on rise");
    free_space = 12'd10;
    @(negedge clk);
    auto_en = 1'b1;
    watch_idle(6, "R9 no replay");
    free_space = 12'd500;
    @(negedge clk);
    expect_start("R8 resume after enable");
    collect(0);
    verify(16'h0000, 48'h0A0B_0C0D_0E0F, "R8 resume");

    // Half duplex (R10)
    full_duplex = 1'b0;
    pulse_manual();
    free_space = 12'd10;
    watch_idle(6, "R10 dropped in half duplex");
    full_duplex = 1'b1;
    watch_idle(6, "R10 not kept");
    full_duplex = 1'b0;
    free_space = 12'd500;
    watch_idle(4, "R10 rise dropped");
    full_duplex = 1'b1;
    watch_idle(6, "R10 rise not kept");

    // Pause and resume both pending behind a frame (R11)
    pause_quanta = 16'h0C0D; src_mac = 48'h0055_6677_8899;
    pulse_manual();
    expect_start("R6 manual latency");
    out_ready = 1'b0;
    free_space = 12'd10;
    @(negedge clk);
    free_space = 12'd500;
    @(negedge clk);
    collect(0);
    verify(16'h0C0D, 48'h0055_6677_8899, "R11 first");
    gap_then_start("R11 second after gap");
    collect(0);
    verify(16'h0C0D, 48'h0055_6677_8899, "R11 pause before resume");
    gap_then_start("R11 third after gap");
    collect(1);
    verify(16'h0000, 48'h0055_6677_8899, "R11 resume last");
    watch_idle(6, "R11 nothing more");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule